// File: doc/BRIEF.md
# Porter-Duff Pixel Compositor

This block merges two premultiplied RGBA pixels, a source and a destination, into one result pixel. Each 32-bit pixel holds four 8-bit channels. An operator code picks a pair of weighting factors (Fa for the source, Fb for the destination). Every channel, alpha included, is then formed as C = Ca·Fa + Cb·Fb.

Before the operator is applied, a flag field can scale the whole source by one constant alpha and the whole destination by another. Pixels enter and leave through valid/ready handshakes. A three-register pipeline can take one pixel on every clock, and results leave in the order they arrived.

The block does not fetch pixels, walk rectangles or convert colour formats. Its caller supplies pixel pairs and drains the results.

Top module: `pd_blend_unit`

## Requirements
- R1: A pixel packs channel k in bits [8k+7:8k], and channel 3 is alpha. The value 255 stands for 1.0. Operator 0 (Clear) gives 0, operator 1 (Src) passes the source and operator 2 (Dst) passes the destination.
- R2: Each product x·y/255 is rounded to the nearest integer, which equals floor((x·y + 127)/255).
- R3: Operators 3 to 6 use these factor pairs: 3 uses (1, 1−Aa), 4 uses (1−Ab, 1), 5 uses (Ab, 0) and 6 uses (0, Aa). Aa is the source alpha and Ab is the destination alpha.
- R4: Operators 7 to 11 use these factor pairs: 7 uses (1−Ab, 0), 8 uses (0, 1−Aa), 9 uses (Ab, 1−Aa), 10 uses (1−Ab, Aa) and 11 uses (1−Ab, 1−Aa).
- R5: Operator 12 uses the factor pair (1, 1). Every channel sum is clamped to 255.
- R6: Operator 13 uses Fb = 1 and Fa = min(255, floor((255−Ab)·255/Aa)). When Aa is 0, Fa is 255.
- R7: Flag bit 0 scales all four source channels by param0. Flag bit 1 scales all four destination channels by param1. The scaling is applied before the operator, and the scaled alphas feed the factors.
- R8: An operator code of 14 or above, or a flag field with any bit above bit 1 set, produces a zero pixel.
- R9: err_sticky rises on the clock edge that accepts an invalid pixel (R8). Only reset clears it, and valid pixels never set it.
- R10: A pixel accepted on an edge appears on the output after the second following edge. One pixel can be accepted per clock, and results keep the input order.
- R11: While out_valid is high and out_ready is low, out_valid and out_pixel hold steady.
- R12: During reset out_valid and err_sticky are low. in_ready is high once the pipeline is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel pair is offered |
| in_ready | output | 1 | Block accepts the offered pair |
| src_pixel | input | 32 | Source pixel A |
| dst_pixel | input | 32 | Destination pixel B |
| op | input | 4 | Operator code |
| flags | input | 4 | Constant-alpha flags; bits above 1 are invalid |
| param0 | input | 8 | Constant alpha for the source |
| param1 | input | 8 | Constant alpha for the destination |
| out_valid | output | 1 | Result pixel is present |
| out_ready | input | 1 | Consumer takes the result |
| out_pixel | output | 32 | Result pixel |
| err_sticky | output | 1 | An invalid pixel pair was accepted |

## Verification
A wrong factor or rounding step appears as a mismatched result pixel when that pixel leaves the pipeline, two edges after it was accepted. Each result is compared against a behavioural model at that handshake. A stage register that loses or repeats a pixel shows up as a queue mismatch, or as an unexpected output, at the next output handshake. A corrupted hold during stalls is caught on the very next clock. A wrong error bit is visible one edge after the offending pixel was accepted, because err_sticky is compared on every clock.

// File: rtl/pd_blend_pkg.sv
`timescale 1ns/1ps
package pd_blend_pkg;
   localparam int PD_OP_W = 4;

   typedef enum logic [PD_OP_W-1:0] {
      OP_CLEAR    = 4'd0,
      OP_SRC      = 4'd1,
      OP_DST      = 4'd2,
      OP_OVER     = 4'd3,
      OP_OVER_REV = 4'd4,
      OP_IN       = 4'd5,
      OP_IN_REV   = 4'd6,
      OP_OUT      = 4'd7,
      OP_OUT_REV  = 4'd8,
      OP_ATOP     = 4'd9,
      OP_ATOP_REV = 4'd10,
      OP_XOR      = 4'd11,
      OP_ADD      = 4'd12,
      OP_SAT      = 4'd13
   } pd_op_e;

   localparam logic [PD_OP_W-1:0] PD_NUM_OPS = 4'd14;
endpackage

// File: rtl/pd_mul_norm.sv
`timescale 1ns/1ps
module pd_mul_norm #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] p
);
   localparam int PW = 2*W + 1;
   localparam logic [PW-1:0] HALF = {{(PW-1){1'b0}}, 1'b1} << (W-1);

   logic [PW-1:0] t;
   logic [PW-1:0] s;

   always_comb begin
      t = PW'(a) * PW'(b) + HALF;
      s = t + (t >> W);
      p = W'(s >> W);
   end

   always_comb begin
      // R2
      if (b == '1) begin
         unity_gain_chk: assert (p == a);
      end
      // R2
      if (b == '0) begin
         zero_gain_chk: assert (p == '0);
      end
   end
endmodule

// File: rtl/pd_factor_sel.sv
`timescale 1ns/1ps
module pd_factor_sel
   import pd_blend_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [PD_OP_W-1:0] op,
   input  logic [W-1:0]       aa,
   input  logic [W-1:0]       ab,
   output logic [W-1:0]       fa,
   output logic [W-1:0]       fb
);
   localparam logic [W-1:0] ONE = '1;

   logic [W-1:0]   naa, nab, den, fsat;
   logic [2*W-1:0] prod;

   always_comb begin
      naa  = ONE - aa;
      nab  = ONE - ab;
      den  = (aa == '0) ? {{(W-1){1'b0}}, 1'b1} : aa;
      prod = (2*W)'(nab) * (2*W)'(ONE);
      if (aa == '0 || nab >= aa) fsat = ONE;
      else                       fsat = W'(prod / (2*W)'(den));
   end

   always_comb begin
      fa = '0;
      fb = '0;
      case (op)
         OP_CLEAR:    begin fa = '0;   fb = '0;   end
         OP_SRC:      begin fa = ONE;  fb = '0;   end
         OP_DST:      begin fa = '0;   fb = ONE;  end
         OP_OVER:     begin fa = ONE;  fb = naa;  end
         OP_OVER_REV: begin fa = nab;  fb = ONE;  end
         OP_IN:       begin fa = ab;   fb = '0;   end
         OP_IN_REV:   begin fa = '0;   fb = aa;   end
         OP_OUT:      begin fa = nab;  fb = '0;   end
         OP_OUT_REV:  begin fa = '0;   fb = naa;  end
         OP_ATOP:     begin fa = ab;   fb = naa;  end
         OP_ATOP_REV: begin fa = nab;  fb = aa;   end
         OP_XOR:      begin fa = nab;  fb = naa;  end
         OP_ADD:      begin fa = ONE;  fb = ONE;  end
         OP_SAT:      begin fa = fsat; fb = ONE;  end
         default:     begin fa = '0;   fb = '0;   end
      endcase
   end
endmodule

// File: rtl/pd_blend_unit.sv
`timescale 1ns/1ps
module pd_blend_unit
   import pd_blend_pkg::*;
#(
   parameter int CH_W     = 8,
   parameter int NCH      = 4,
   parameter int ALPHA_CH = 3,
   parameter int FLAG_W   = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [CH_W*NCH-1:0]    src_pixel,
   input  logic [CH_W*NCH-1:0]    dst_pixel,
   input  logic [PD_OP_W-1:0]     op,
   input  logic [FLAG_W-1:0]      flags,
   input  logic [CH_W-1:0]        param0,
   input  logic [CH_W-1:0]        param1,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [CH_W*NCH-1:0]    out_pixel,
   output logic                   err_sticky
);
   localparam int PIX_W = CH_W * NCH;
   localparam logic [CH_W-1:0] CH_MAX = '1;

   initial begin
      cfg_chw_chk:   assert (CH_W >= 2 && CH_W <= 16) else $error("CH_W out of range");
      cfg_alpha_chk: assert (ALPHA_CH >= 0 && ALPHA_CH < NCH) else $error("ALPHA_CH out of range");
      cfg_flag_chk:  assert (FLAG_W >= 2) else $error("FLAG_W must be at least 2");
      cfg_pix_chk:   assert (PIX_W >= 2*CH_W) else $error("need at least two channels");
   end

   // ---------------- handshake / advance chain ----------------
   logic v1, v2;
   logic adv1, adv2, adv3;

   always_comb begin
      adv3     = !out_valid || out_ready;
      adv2     = !v2 || adv3;
      adv1     = !v1 || adv2;
      in_ready = adv1;
   end

   // ---------------- stage 0: validity and constant-alpha scaling ----------------
   logic flag_hi_bad, bad0;

   if (FLAG_W > 2) begin : g_flag_hi
      assign flag_hi_bad = |flags[FLAG_W-1:2];
   end else begin : g_flag_none
      assign flag_hi_bad = 1'b0;
   end

   assign bad0 = (op >= PD_NUM_OPS) || flag_hi_bad;

   logic [NCH-1:0][CH_W-1:0] src_ch, dst_ch, msrc, mdst, ssrc, sdst;
   assign src_ch = src_pixel;
   assign dst_ch = dst_pixel;

   for (genvar c = 0; c < NCH; c++) begin : g_scale
      pd_mul_norm #(.W(CH_W)) u_msrc (.a(src_ch[c]), .b(param0), .p(msrc[c]));
      pd_mul_norm #(.W(CH_W)) u_mdst (.a(dst_ch[c]), .b(param1), .p(mdst[c]));
      assign ssrc[c] = flags[0] ? msrc[c] : src_ch[c];
      assign sdst[c] = flags[1] ? mdst[c] : dst_ch[c];
   end

   logic [NCH-1:0][CH_W-1:0] s1_src, s1_dst;
   logic [PD_OP_W-1:0]       s1_op;
   logic                     s1_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
      end else if (adv1) begin
         v1 <= in_valid;
      end
      if (adv1 && in_valid) begin
         s1_src <= ssrc;
         s1_dst <= sdst;
         s1_op  <= op;
         s1_bad <= bad0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                          err_sticky <= 1'b0;
      else if (in_valid && adv1 && bad0)   err_sticky <= 1'b1;
   end

   // ---------------- stage 1: factor selection ----------------
   logic [CH_W-1:0] fa1, fb1;

   pd_factor_sel #(.W(CH_W)) u_fsel (
      .op (s1_op),
      .aa (s1_src[ALPHA_CH]),
      .ab (s1_dst[ALPHA_CH]),
      .fa (fa1),
      .fb (fb1)
   );

   logic [NCH-1:0][CH_W-1:0] s2_src, s2_dst;
   logic [CH_W-1:0]          s2_fa, s2_fb;
   logic                     s2_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2 <= 1'b0;
      end else if (adv2) begin
         v2 <= v1;
      end
      if (adv2 && v1) begin
         s2_src <= s1_src;
         s2_dst <= s1_dst;
         s2_fa  <= fa1;
         s2_fb  <= fb1;
         s2_bad <= s1_bad;
      end
   end

   // ---------------- stage 2: weighted sum and clamp ----------------
   logic [NCH-1:0][CH_W-1:0] pa, pb, res;

   for (genvar c = 0; c < NCH; c++) begin : g_sum
      logic [CH_W:0] sum;
      pd_mul_norm #(.W(CH_W)) u_pa (.a(s2_src[c]), .b(s2_fa), .p(pa[c]));
      pd_mul_norm #(.W(CH_W)) u_pb (.a(s2_dst[c]), .b(s2_fb), .p(pb[c]));
      assign sum    = {1'b0, pa[c]} + {1'b0, pb[c]};
      assign res[c] = s2_bad ? '0 : (sum[CH_W] ? CH_MAX : sum[CH_W-1:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (adv3) begin
         out_valid <= v2;
      end
      if (adv3 && v2) begin
         out_pixel <= res;
      end
   end

   // ---------------- assertions ----------------
   // R11
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

   // R9
   err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (op >= PD_NUM_OPS)) |=> err_sticky);

   // R10
   empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !v1 && !v2) |-> in_ready);

   // R10
   no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready || !v2 || !v1);
endmodule

// File: tb/pd_blend_unit_test.sv
`timescale 1ns/1ps
module pd_blend_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] src_pixel = '0, dst_pixel = '0;
   logic [3:0]  op = '0;
   logic [3:0]  flags = '0;
   logic [7:0]  param0 = '0, param1 = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_pixel;
   logic        err_sticky;

   always #2.5 clk = ~clk;

   pd_blend_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .src_pixel(src_pixel), .dst_pixel(dst_pixel), .op(op), .flags(flags),
      .param0(param0), .param1(param1), .out_valid(out_valid),
      .out_ready(out_ready), .out_pixel(out_pixel), .err_sticky(err_sticky)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit rand_ready = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int mulr(input int x, input int y);
      return (x * y + 127) / 255;
   endfunction

   function automatic logic [31:0] blend_ref(input logic [31:0] s, input logic [31:0] d,
                                             input int o, input int fl, input int p0, input int p1);
      int a[4];
      int b[4];
      int fa, fb, aa, ab, v;
      logic [31:0] r;
      for (int c = 0; c < 4; c++) begin
         a[c] = int'(s[8*c +: 8]);
         b[c] = int'(d[8*c +: 8]);
         if ((fl & 1) != 0) a[c] = mulr(a[c], p0);
         if ((fl & 2) != 0) b[c] = mulr(b[c], p1);
      end
      if (o >= 14 || fl > 3) return 32'h0;
      aa = a[3];
      ab = b[3];
      fa = 0; fb = 0;
      case (o)
         0:  begin fa = 0;        fb = 0;        end
         1:  begin fa = 255;      fb = 0;        end
         2:  begin fa = 0;        fb = 255;      end
         3:  begin fa = 255;      fb = 255 - aa; end
         4:  begin fa = 255 - ab; fb = 255;      end
         5:  begin fa = ab;       fb = 0;        end
         6:  begin fa = 0;        fb = aa;       end
         7:  begin fa = 255 - ab; fb = 0;        end
         8:  begin fa = 0;        fb = 255 - aa; end
         9:  begin fa = ab;       fb = 255 - aa; end
         10: begin fa = 255 - ab; fb = aa;       end
         11: begin fa = 255 - ab; fb = 255 - aa; end
         12: begin fa = 255;      fb = 255;      end
         default: begin
            fb = 255;
            if (aa == 0 || (255 - ab) >= aa) fa = 255;
            else fa = ((255 - ab) * 255) / aa;
         end
      endcase
      for (int c = 0; c < 4; c++) begin
         v = mulr(a[c], fa) + mulr(b[c], fb);
         if (v > 255) v = 255;
         r[8*c +: 8] = 8'(v);
      end
      return r;
   endfunction

   function automatic string req_tag(input int o, input int fl);
      if (o >= 14 || fl > 3) return "R8";
      if (o == 1 && fl == 1) return "R2";
      if (fl != 0)           return "R7";
      if (o <= 2)            return "R1";
      if (o <= 6)            return "R3";
      if (o <= 11)           return "R4";
      if (o == 12)           return "R5";
      return "R6";
   endfunction

   // ---------------- per-clock reference comparison ----------------
   logic [31:0] exp_q[$];
   string       tag_q[$];
   bit          m_err = 0;
   bit          prev_stall = 0;
   logic [31:0] prev_pix = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk(err_sticky == m_err, "R9", {31'h0, err_sticky}, {31'h0, m_err});
         if (prev_stall)
            chk(out_valid && out_pixel == prev_pix, "R11", out_pixel, prev_pix);
         prev_stall = out_valid && !out_ready;
         prev_pix   = out_pixel;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", out_pixel, 32'h0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(out_pixel == e, t, out_pixel, e);
            end
         end
         if (in_valid && in_ready) begin
            exp_q.push_back(blend_ref(src_pixel, dst_pixel, int'(op), int'(flags),
                                      int'(param0), int'(param1)));
            tag_q.push_back(req_tag(int'(op), int'(flags)));
            if (op >= 4'd14 || flags > 4'd3) m_err = 1;
         end
      end
   end

   always @(posedge clk) begin
      #1;
      out_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
   end

   task automatic send(input logic [31:0] s, input logic [31:0] d, input logic [3:0] o,
                       input logic [3:0] fl, input logic [7:0] p0, input logic [7:0] p1);
      src_pixel = s; dst_pixel = d; op = o; flags = fl; param0 = p0; param1 = p1;
      in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(out_valid == 1'b0, "R12", {31'h0, out_valid}, 32'h0);
      chk(err_sticky == 1'b0, "R12", {31'h0, err_sticky}, 32'h0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R12", {31'h0, in_ready}, 32'h1);
      @(posedge clk);
      #1;

      // R10 latency: result after the second edge following acceptance
      send(32'h80_40_C0_20, 32'h60_A0_10_F0, 4'd1, 4'd0, 8'd0, 8'd0);
      for (int n = 1; n <= 3; n++) begin
         @(negedge clk);
         chk(out_valid == (n == 3), "R10", {31'h0, out_valid}, {31'h0, 1'(n == 3)});
      end
      @(posedge clk);
      #1;

      // R1 R3 R4 R5 R6 every operator, back to back
      for (int o = 0; o < 14; o++)
         send(32'h80_40_C0_20, 32'h60_A0_10_F0, 4'(o), 4'd0, 8'd0, 8'd0);
      // R5 clamp
      send(32'hC0_C0_C0_C0, 32'hC0_C0_C0_C0, 4'd12, 4'd0, 8'd0, 8'd0);
      // R6 zero source alpha, then a divide below one
      send(32'h00_30_20_10, 32'h80_40_40_40, 4'd13, 4'd0, 8'd0, 8'd0);
      send(32'hF0_50_60_70, 32'hA0_20_30_40, 4'd13, 4'd0, 8'd0, 8'd0);
      // R2 rounding, hand-worked value
      chk(blend_ref(32'hC8_00_FF_01, 32'h0, 1, 1, 128, 0) == 32'h64_00_80_01, "R2",
          blend_ref(32'hC8_00_FF_01, 32'h0, 1, 1, 128, 0), 32'h64_00_80_01);
      send(32'hC8_00_FF_01, 32'h0, 4'd1, 4'd1, 8'd128, 8'd0);
      // R7 constant alpha before the operator
      send(32'hFF_80_40_20, 32'hFF_10_20_30, 4'd12, 4'd3, 8'h40, 8'h90);
      send(32'hFF_80_40_20, 32'h80_10_20_30, 4'd2, 4'd2, 8'h40, 8'h90);
      send(32'hFF_80_40_20, 32'h80_10_20_30, 4'd3, 4'd1, 8'h33, 8'h00);

      // random stream with back-pressure
      rand_ready = 1;
      for (int i = 0; i < 600; i++) begin
         send($urandom, $urandom, 4'($urandom_range(0, 13)), 4'($urandom_range(0, 3)),
              8'($urandom), 8'($urandom));
         idle($urandom_range(0, 2) == 0 ? 1 : 0);
      end

      // R8 R9 invalid operators and flags
      send(32'hFF_FF_FF_FF, 32'hFF_FF_FF_FF, 4'd14, 4'd0, 8'd0, 8'd0);
      send(32'h12_34_56_78, 32'h9A_BC_DE_F0, 4'd3, 4'd4, 8'd0, 8'd0);
      send(32'h12_34_56_78, 32'h9A_BC_DE_F0, 4'd15, 4'd0, 8'd0, 8'd0);
      send(32'h80_40_C0_20, 32'h60_A0_10_F0, 4'd3, 4'd0, 8'd0, 8'd0);

      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(err_sticky == 1'b1, "R9", {31'h0, err_sticky}, 32'h1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual %0d expected %0d", exp_q.size(), 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule